// File: doc/BRIEF.md
# Accumulator Processor with Hardwired Sequencing

This block is a compact 16-bit processor built around one accumulator and a carry bit. It holds its own 4096-word by 16-bit memory, which a loader fills through a side port while the core is held in reset. After reset is released the core fetches from address 0 and executes until a halt instruction clears its run flag. A 4-bit step counter feeds a decoder that produces one-hot step strobes, and every register transfer is tied to one step strobe combined with the decoded opcode. Each transfer moves a value across one shared internal bus.

An instruction word holds an indirect flag in bit 15, a 3-bit opcode in bits 14..12 and a 12-bit address in bits 11..0. Opcodes 0 to 6 are memory operations: AND, ADD, LDA, STA, BUN, BSA and ISZ, in that numeric order. Opcode 7 with the indirect flag clear is a register operation, and with the flag set it is a character I/O operation. In both cases one set bit among bits 11..0 selects the operation. A character port with ready flags on each side connects an outside device. When interrupts are enabled and a ready flag is raised, a hardware interrupt cycle stores the return address at word 0 and continues at word 1.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, pc and ac are 0, e_flag and ien are 0, run is 1, in_flag is 0, out_flag is 1 and out_char is 0. The memory keeps its contents through reset, and the side port writes it when bd_we is high.
- R2: Each instruction is fetched from the address in the PC, which then increments. Opcode 0 (AND) sets AC to AC AND M[addr]. Opcode 1 (ADD) sets AC to AC + M[addr], with the carry-out going to E. Opcode 2 (LDA) sets AC to M[addr].
- R3: When bit 15 of a memory instruction is set, the word at the address field is taken as the effective address.
- R4: Opcode 3 (STA) stores AC at the effective address. Opcode 4 (BUN) jumps to it. Opcode 5 (BSA) stores the return address at the effective address, with bits 15..12 zero, and continues at the effective address plus one.
- R5: Opcode 6 (ISZ) increments the memory word modulo 2^16, writes it back, and skips the next instruction when the result is 0.
- R6: The register operations have codes 7800 CLA (AC to 0), 7400 CLE (E to 0), 7200 CMA (invert AC), 7100 CME (invert E), 7080 CIR (rotate E and AC right, AC bit 0 into E), 7040 CIL (rotate left, AC bit 15 into E) and 7020 INC (AC+1, E unchanged). All codes are hex.
- R7: The skip codes are 7010 (skip if AC bit 15 is 0), 7008 (skip if AC bit 15 is 1), 7004 (skip if AC is 0) and 7002 (skip if E is 0).
- R8: Code 7001 clears run. While run is 0, pc, ac, e_flag and memory do not change.
- R9: A pulse on in_strobe loads in_char and sets in_flag. Code F800 copies that character into AC bits 7..0, leaves AC bits 15..8 unchanged and clears in_flag. Code F400 copies AC bits 7..0 to out_char and clears out_flag. A pulse on out_ack sets out_flag.
- R10: Code F200 skips if in_flag is 1. Code F100 skips if out_flag is 1.
- R11: Code F080 sets ien and code F040 clears it. An interrupt is requested on an edge where the step is not 0, 1 or 2, ien is 1 and a ready flag is 1.
- R12: When an interrupt is pending, the next fetch is replaced by a cycle that stores the PC at word 0, sets the PC to 1, clears ien and clears the request.
- R13: Step counts are 4 cycles for register, I/O and halt instructions, 5 for STA and BUN, 6 for AND, ADD, LDA and BSA, and 7 for ISZ. The count is the same with or without indirect addressing, and the step counter never passes 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bd_we | input | 1 | Side-port memory write enable |
| bd_addr | input | 12 | Side-port memory address |
| bd_wdata | input | 16 | Side-port write data |
| bd_rdata | output | 16 | Side-port read data (asynchronous) |
| in_char | input | 8 | Character from the input device |
| in_strobe | input | 1 | Input character valid pulse |
| out_ack | input | 1 | Output device has taken the character |
| out_char | output | 8 | Output character register |
| out_flag | output | 1 | Output register free |
| in_flag | output | 1 | Input character waiting |
| run | output | 1 | Start/stop flag |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| e_flag | output | 1 | Carry/extension bit |
| ien | output | 1 | Interrupt enable |

## Verification
The bench runs short programs that hit carry-out on a wrapping ADD, rotation through E in both directions, and an ISZ that wraps to zero next to one that does not. A wrong skip decision or carry shows up as a halt at the wrong PC or a wrong E. Indirect loads and a BSA return-address write are checked in memory: a design that skips the pointer read would load the pointer itself, and one that lets stray upper bits into the return word would store a wrong value. An interrupt that fires right after an enable proves the saved return address and the vector at word 1. A program with both flags low proves that no interrupt fires when the flags are low. Cycle counts from reset to halt catch a missing or extra step in the sequence.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    ALU_NOP,
    ALU_AND,
    ALU_ADD,
    ALU_LOAD,
    ALU_CLR,
    ALU_CLRE,
    ALU_CMP,
    ALU_CMPE,
    ALU_ROR,
    ALU_ROL,
    ALU_INC,
    ALU_LDCHAR
  } alu_op_e;

  typedef enum logic [2:0] {
    BUS_NONE,
    BUS_AR,
    BUS_PC,
    BUS_DR,
    BUS_AC,
    BUS_IR,
    BUS_TR,
    BUS_MEM
  } bus_sel_e;

  // Register-operation select bits
  localparam int RB_CLA = 11;
  localparam int RB_CLE = 10;
  localparam int RB_CMA = 9;
  localparam int RB_CME = 8;
  localparam int RB_CIR = 7;
  localparam int RB_CIL = 6;
  localparam int RB_INC = 5;
  localparam int RB_SPA = 4;
  localparam int RB_SNA = 3;
  localparam int RB_SZA = 2;
  localparam int RB_SZE = 1;
  localparam int RB_HLT = 0;

  // Character I/O select bits
  localparam int IB_INP = 11;
  localparam int IB_OUT = 10;
  localparam int IB_SKI = 9;
  localparam int IB_SKO = 8;
  localparam int IB_ION = 7;
  localparam int IB_IOF = 6;

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [DW-1:0] bd_wdata,
  output logic [DW-1:0] bd_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (bd_we) begin
      mem[bd_addr] <= bd_wdata;
    end else if (cpu_we) begin
      mem[cpu_addr] <= cpu_wdata;
    end
  end

  assign cpu_rdata = mem[cpu_addr];
  assign bd_rdata  = mem[bd_addr];
endmodule

// File: rtl/acc_timing.sv
module acc_timing #(
  parameter int SCW  = 4,
  parameter int LAST = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                clr,
  output logic [(1<<SCW)-1:0] t_o
);
  localparam int NST = 1 << SCW;

  logic [SCW-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_q <= '0;
    end else if (clr) begin
      sc_q <= '0;
    end else if (adv) begin
      sc_q <= sc_q + SCW'(1);
    end
  end

  for (genvar g = 0; g < NST; g++) begin : g_dec
    assign t_o[g] = (sc_q == SCW'(g));
  end

  // R13: every instruction ends by step LAST
  assert_sc_bound_R13: assert property (@(posedge clk) disable iff (rst)
    (int'(sc_q) <= LAST));
endmodule

// File: rtl/acc_prio.sv
module acc_prio #(
  parameter int W  = 12,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (bits_i[k]) begin
        idx_o   = IW'(k);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] ac_i,
  input  logic [DW-1:0] dr_i,
  input  logic          e_i,
  input  logic [CW-1:0] chr_i,
  output logic [DW-1:0] ac_o,
  output logic          e_o
);
  logic [DW:0] sum;
  assign sum = {1'b0, ac_i} + {1'b0, dr_i};

  always_comb begin
    ac_o = ac_i;
    e_o  = e_i;
    unique case (op_i)
      ALU_AND:    ac_o = ac_i & dr_i;
      ALU_ADD:    {e_o, ac_o} = sum;
      ALU_LOAD:   ac_o = dr_i;
      ALU_CLR:    ac_o = '0;
      ALU_CLRE:   e_o  = 1'b0;
      ALU_CMP:    ac_o = ~ac_i;
      ALU_CMPE:   e_o  = ~e_i;
      ALU_ROR:    begin ac_o = {e_i, ac_i[DW-1:1]}; e_o = ac_i[0];    end
      ALU_ROL:    begin ac_o = {ac_i[DW-2:0], e_i}; e_o = ac_i[DW-1]; end
      ALU_INC:    ac_o = ac_i + DW'(1);
      ALU_LDCHAR: ac_o = {ac_i[DW-1:CW], chr_i};
      default:    ;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int SCW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [DW-1:0] bd_wdata,
  output logic [DW-1:0] bd_rdata,
  input  logic [CW-1:0] in_char,
  input  logic          in_strobe,
  input  logic          out_ack,
  output logic [CW-1:0] out_char,
  output logic          out_flag,
  output logic          in_flag,
  output logic          run,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic          e_flag,
  output logic          ien
);
  localparam int NST  = 1 << SCW;
  localparam int LAST = 6;

  logic [AW-1:0] pc_q, ar_q;
  logic [DW-1:0] ir_q, dr_q, ac_q, tr_q;
  logic          e_q, fgi_q, fgo_q, ien_q, s_q, r_q, ind_q;
  logic [CW-1:0] inpr_q, outr_q;

  logic [NST-1:0] t;
  logic [7:0]     d;
  logic [2:0]     opc;
  logic [DW-1:0]  bus, mem_rd;
  bus_sel_e       bus_sel;
  alu_op_e        alu_op;
  logic [DW-1:0]  alu_ac;
  logic           alu_e;

  logic [$clog2(AW)-1:0] sel;
  logic                  sel_v;
  logic [AW-1:0]         pick, rrop, ioop;

  logic is_rr, is_io, ind_rd, rd4;
  logic fetch0, fetch1, fetch2, int0, int1, int2;
  logic skip, mem_we, sc_clr, int_req;
  logic unused_t;

  assign unused_t = ^t[NST-1:LAST+1];

  // Step sequencer
  acc_timing #(.SCW(SCW), .LAST(LAST)) i_timing (
    .clk (clk),
    .rst (rst),
    .adv (s_q),
    .clr (sc_clr),
    .t_o (t)
  );

  // Opcode and operation-bit decode
  assign opc = ir_q[AW +: 3];
  assign d   = 8'(1) << opc;

  acc_prio #(.W(AW)) i_prio (
    .bits_i  (ir_q[AW-1:0]),
    .idx_o   (sel),
    .valid_o (sel_v)
  );

  assign pick  = sel_v ? (AW'(1) << sel) : '0;
  assign is_rr = d[7] & ~ind_q & t[3];
  assign is_io = d[7] &  ind_q & t[3];
  assign rrop  = is_rr ? pick : '0;
  assign ioop  = is_io ? pick : '0;

  assign fetch0 = ~r_q & t[0];
  assign fetch1 = ~r_q & t[1];
  assign fetch2 = ~r_q & t[2];
  assign int0   =  r_q & t[0];
  assign int1   =  r_q & t[1];
  assign int2   =  r_q & t[2];
  assign ind_rd = ~d[7] & ind_q & t[3];
  assign rd4    = (d[0] | d[1] | d[2] | d[6]) & t[4];

  // Common bus source select
  always_comb begin
    bus_sel = BUS_NONE;
    if (fetch0 | int0)                  bus_sel = BUS_PC;
    else if (int1)                      bus_sel = BUS_TR;
    else if (fetch1 | ind_rd | rd4)     bus_sel = BUS_MEM;
    else if (fetch2)                    bus_sel = BUS_IR;
    else if ((d[3] & t[4]) | ioop[IB_OUT]) bus_sel = BUS_AC;
    else if ((d[4] & t[4]) | (d[5] & t[5])) bus_sel = BUS_AR;
    else if (d[5] & t[4])               bus_sel = BUS_PC;
    else if (d[6] & t[6])               bus_sel = BUS_DR;
  end

  always_comb begin
    unique case (bus_sel)
      BUS_AR:  bus = {{(DW-AW){1'b0}}, ar_q};
      BUS_PC:  bus = {{(DW-AW){1'b0}}, pc_q};
      BUS_DR:  bus = dr_q;
      BUS_AC:  bus = ac_q;
      BUS_IR:  bus = ir_q;
      BUS_TR:  bus = tr_q;
      BUS_MEM: bus = mem_rd;
      default: bus = '0;
    endcase
  end

  // Memory
  assign mem_we = s_q & ((d[3] & t[4]) | (d[5] & t[4]) | (d[6] & t[6]) | int1);

  acc_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk       (clk),
    .cpu_we    (mem_we),
    .cpu_addr  (ar_q),
    .cpu_wdata (bus),
    .cpu_rdata (mem_rd),
    .bd_we     (bd_we),
    .bd_addr   (bd_addr),
    .bd_wdata  (bd_wdata),
    .bd_rdata  (bd_rdata)
  );

  // Accumulator logic
  always_comb begin
    alu_op = ALU_NOP;
    if (t[5] & d[0])           alu_op = ALU_AND;
    else if (t[5] & d[1])      alu_op = ALU_ADD;
    else if (t[5] & d[2])      alu_op = ALU_LOAD;
    else if (rrop[RB_CLA])     alu_op = ALU_CLR;
    else if (rrop[RB_CLE])     alu_op = ALU_CLRE;
    else if (rrop[RB_CMA])     alu_op = ALU_CMP;
    else if (rrop[RB_CME])     alu_op = ALU_CMPE;
    else if (rrop[RB_CIR])     alu_op = ALU_ROR;
    else if (rrop[RB_CIL])     alu_op = ALU_ROL;
    else if (rrop[RB_INC])     alu_op = ALU_INC;
    else if (ioop[IB_INP])     alu_op = ALU_LDCHAR;
  end

  acc_alu #(.DW(DW), .CW(CW)) i_alu (
    .op_i  (alu_op),
    .ac_i  (ac_q),
    .dr_i  (dr_q),
    .e_i   (e_q),
    .chr_i (inpr_q),
    .ac_o  (alu_ac),
    .e_o   (alu_e)
  );

  // Skip, step clear and interrupt request
  assign skip = (rrop[RB_SPA] & ~ac_q[DW-1]) |
                (rrop[RB_SNA] &  ac_q[DW-1]) |
                (rrop[RB_SZA] & (ac_q == '0)) |
                (rrop[RB_SZE] & ~e_q) |
                (ioop[IB_SKI] & fgi_q) |
                (ioop[IB_SKO] & fgo_q) |
                (d[6] & t[6] & (dr_q == '0));

  assign sc_clr = s_q & (is_rr | is_io | int2 |
                  ((d[0] | d[1] | d[2] | d[5]) & t[5]) |
                  ((d[3] | d[4]) & t[4]) |
                  (d[6] & t[6]));

  assign int_req = ~(t[0] | t[1] | t[2]) & ien_q & (fgi_q | fgo_q);

  // Register transfers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ar_q   <= '0;
      ir_q   <= '0;
      dr_q   <= '0;
      ac_q   <= '0;
      tr_q   <= '0;
      e_q    <= 1'b0;
      inpr_q <= '0;
      outr_q <= '0;
      fgi_q  <= 1'b0;
      fgo_q  <= 1'b1;
      ien_q  <= 1'b0;
      s_q    <= 1'b1;
      r_q    <= 1'b0;
      ind_q  <= 1'b0;
    end else begin
      if (in_strobe) begin
        inpr_q <= in_char;
        fgi_q  <= 1'b1;
      end
      if (out_ack) fgo_q <= 1'b1;

      if (s_q) begin
        if (int0) begin
          ar_q <= '0;
          tr_q <= bus;
        end
        if (int1) pc_q <= '0;
        if (int2) begin
          pc_q  <= pc_q + AW'(1);
          ien_q <= 1'b0;
          r_q   <= 1'b0;
        end
        if (fetch0 | ind_rd) ar_q <= bus[AW-1:0];
        if (fetch1) begin
          ir_q <= bus;
          pc_q <= pc_q + AW'(1);
        end
        if (fetch2) begin
          ar_q  <= bus[AW-1:0];
          ind_q <= bus[DW-1];
        end
        if (rd4) dr_q <= bus;
        if ((d[4] & t[4]) | (d[5] & t[5])) pc_q <= bus[AW-1:0];
        if (d[5] & t[4]) ar_q <= ar_q + AW'(1);
        if (d[6] & t[5]) dr_q <= dr_q + DW'(1);
        if (alu_op != ALU_NOP) begin
          ac_q <= alu_ac;
          e_q  <= alu_e;
        end
        if (skip) pc_q <= pc_q + AW'(1);
        if (rrop[RB_HLT]) s_q <= 1'b0;
        if (ioop[IB_INP]) fgi_q <= 1'b0;
        if (ioop[IB_OUT]) begin
          outr_q <= bus[CW-1:0];
          fgo_q  <= 1'b0;
        end
        if (ioop[IB_ION]) ien_q <= 1'b1;
        if (ioop[IB_IOF]) ien_q <= 1'b0;
        if (int_req) r_q <= 1'b1;
      end
    end
  end

  assign run      = s_q;
  assign pc       = pc_q;
  assign ac       = ac_q;
  assign e_flag   = e_q;
  assign ien      = ien_q;
  assign in_flag  = fgi_q;
  assign out_flag = fgo_q;
  assign out_char = outr_q;

  // R2: the fetch address comes from the PC
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (s_q && !r_q && t[0]) |=> (ar_q == $past(pc_q)));

  // R8: a stopped core holds its state
  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    !s_q |=> (!s_q && $stable(pc_q) && $stable(ac_q) && $stable(e_q)));

  // R9: an output operation leaves the output register busy
  assert_out_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (s_q && ioop[IB_OUT]) |=> !fgo_q);

  // R12: the interrupt cycle ends at the vector with interrupts off
  assert_int_vector_R12: assert property (@(posedge clk) disable iff (rst)
    (s_q && r_q && t[2]) |=> (pc_q == AW'(1) && !ien_q && !r_q));
endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/100ps
module test_acc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bd_we = 1'b0;
  logic [11:0] bd_addr = '0;
  logic [15:0] bd_wdata = '0;
  logic [15:0] bd_rdata;
  logic [7:0]  in_char = '0;
  logic        in_strobe = 1'b0;
  logic        out_ack = 1'b0;
  logic [7:0]  out_char;
  logic        out_flag, in_flag, run, e_flag, ien;
  logic [11:0] pc;
  logic [15:0] ac;

  always #2 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst(rst), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
    .bd_rdata(bd_rdata), .in_char(in_char), .in_strobe(in_strobe), .out_ack(out_ack),
    .out_char(out_char), .out_flag(out_flag), .in_flag(in_flag), .run(run),
    .pc(pc), .ac(ac), .e_flag(e_flag), .ien(ien)
  );

  typedef struct {
    string       tag;
    logic [15:0] ac;
    logic        e;
    logic [11:0] pc;
    logic        ien;
    logic [7:0]  oc;
    logic        of;
    logic        inf;
    int          nm;
    logic [11:0] ma0, ma1;
    logic [15:0] mv0, mv1;
  } exp_t;

  exp_t sb[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   done_cnt = 0;
  bit   finished = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R13: got timeout expected halt");
    finish_run();
  end

  function automatic exp_t blank(string tag, logic [11:0] p);
    exp_t x;
    x.tag = tag; x.ac = '0; x.e = 1'b0; x.pc = p; x.ien = 1'b0;
    x.oc = '0; x.of = 1'b1; x.inf = 1'b0; x.nm = 0;
    x.ma0 = '0; x.ma1 = '0; x.mv0 = '0; x.mv1 = '0;
    return x;
  endfunction

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic poke(logic [11:0] a, logic [15:0] v);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_wdata = v;
  endtask

  // Driver: push expectation, release reset, count cycles to halt
  task automatic go(exp_t x, int strobe_at, output int cyc);
    int target;
    sb.push_back(x);
    target = done_cnt + 1;
    @(negedge clk);
    bd_we = 1'b0;
    rst = 1'b0;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      in_strobe = 1'b0;
      if (cyc == strobe_at) begin
        in_char = 8'h5A;
        in_strobe = 1'b1;
      end
      if (!run) break;
    end
    in_strobe = 1'b0;
    wait (done_cnt == target);
  endtask

  // Monitor: compare halted state against the scoreboard
  always @(negedge clk) begin
    if (!rst && !run && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      check(x.tag, "ac", 32'(ac), 32'(x.ac));
      check(x.tag, "e_flag", 32'(e_flag), 32'(x.e));
      check(x.tag, "pc", 32'(pc), 32'(x.pc));
      check(x.tag, "ien", 32'(ien), 32'(x.ien));
      check(x.tag, "out_char", 32'(out_char), 32'(x.oc));
      check(x.tag, "out_flag", 32'(out_flag), 32'(x.of));
      check(x.tag, "in_flag", 32'(in_flag), 32'(x.inf));
      if (x.nm > 0) begin
        bd_addr = x.ma0;
        #0.4;
        check(x.tag, "mem0", 32'(bd_rdata), 32'(x.mv0));
      end
      if (x.nm > 1) begin
        bd_addr = x.ma1;
        #0.4;
        check(x.tag, "mem1", 32'(bd_rdata), 32'(x.mv1));
      end
      done_cnt++;
    end
  end

  initial begin
    exp_t x;
    int   cyc;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "pc", 32'(pc), 32'h0);
    check("R1", "ac", 32'(ac), 32'h0);
    check("R1", "e_flag", 32'(e_flag), 32'h0);
    check("R1", "run", 32'(run), 32'h1);
    check("R1", "ien", 32'(ien), 32'h0);
    check("R1", "flags", {30'h0, in_flag, out_flag}, 32'h1);
    check("R1", "out_char", 32'(out_char), 32'h0);

    // R2: LDA + ADD with carry out
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'h1011); poke(12'h002, 16'h7001);
    poke(12'h010, 16'hFFFF); poke(12'h011, 16'h0003);
    x = blank("R2 add", 12'h003); x.ac = 16'h0002; x.e = 1'b1;
    go(x, 0, cyc);
    check("R13", "add cycles", 32'(cyc), 32'd16);
    // R8: halted state is frozen
    repeat (20) @(negedge clk);
    check("R8", "pc frozen", 32'(pc), 32'h3);
    check("R8", "ac frozen", 32'(ac), 32'h2);
    check("R8", "run low", 32'(run), 32'h0);

    // R2: AND
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'h0011); poke(12'h002, 16'h7001);
    poke(12'h010, 16'hF0F0); poke(12'h011, 16'h3C3C);
    x = blank("R2 and", 12'h003); x.ac = 16'h3030;
    go(x, 0, cyc);

    // R3: indirect load
    hold_reset();
    poke(12'h000, 16'hA010); poke(12'h001, 16'h7001);
    poke(12'h010, 16'h0020); poke(12'h020, 16'h1234);
    x = blank("R3 indirect", 12'h002); x.ac = 16'h1234;
    go(x, 0, cyc);
    check("R13", "indirect cycles", 32'(cyc), 32'd10);

    // R4: STA, BUN, BSA
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'h3030); poke(12'h002, 16'h4005);
    poke(12'h003, 16'h7001); poke(12'h004, 16'h7001); poke(12'h005, 16'h5040);
    poke(12'h006, 16'h7001); poke(12'h010, 16'h00AB); poke(12'h030, 16'h0000);
    poke(12'h040, 16'hFFFF); poke(12'h041, 16'h7020); poke(12'h042, 16'h7001);
    x = blank("R4 store/branch", 12'h043); x.ac = 16'h00AC;
    x.nm = 2; x.ma0 = 12'h030; x.mv0 = 16'h00AB; x.ma1 = 12'h040; x.mv1 = 16'h0006;
    go(x, 0, cyc);

    // R5: ISZ wrap-and-skip, then no skip
    hold_reset();
    poke(12'h000, 16'h6010); poke(12'h001, 16'h7001); poke(12'h002, 16'h6011);
    poke(12'h003, 16'h7001); poke(12'h004, 16'h7001);
    poke(12'h010, 16'hFFFF); poke(12'h011, 16'h0005);
    x = blank("R5 isz", 12'h004);
    x.nm = 2; x.ma0 = 12'h010; x.mv0 = 16'h0000; x.ma1 = 12'h011; x.mv1 = 16'h0006;
    go(x, 0, cyc);
    check("R13", "isz cycles", 32'(cyc), 32'd18);

    // R6: rotates through E, complement, increment
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'h7080); poke(12'h002, 16'h7040);
    poke(12'h003, 16'h7100); poke(12'h004, 16'h7040); poke(12'h005, 16'h7200);
    poke(12'h006, 16'h7020); poke(12'h007, 16'h7001); poke(12'h010, 16'h8001);
    x = blank("R6 rotate", 12'h008); x.ac = 16'hFFFD; x.e = 1'b1;
    go(x, 0, cyc);

    // R6: CLA, CME, CLE, INC
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'h7800); poke(12'h002, 16'h7100);
    poke(12'h003, 16'h7400); poke(12'h004, 16'h7020); poke(12'h005, 16'h7001);
    poke(12'h010, 16'h1234);
    x = blank("R6 clear", 12'h006); x.ac = 16'h0001;
    go(x, 0, cyc);

    // R7: skip taken and not taken
    hold_reset();
    poke(12'h000, 16'h7800); poke(12'h001, 16'h7004); poke(12'h002, 16'h7001);
    poke(12'h003, 16'h7010); poke(12'h004, 16'h7001); poke(12'h005, 16'h7008);
    poke(12'h006, 16'h7002); poke(12'h007, 16'h7001); poke(12'h008, 16'h7200);
    poke(12'h009, 16'h7008); poke(12'h00A, 16'h7001); poke(12'h00B, 16'h7010);
    poke(12'h00C, 16'h7001);
    x = blank("R7 skips", 12'h00D); x.ac = 16'hFFFF;
    go(x, 0, cyc);

    // R9: wait on input flag, INP then OUT
    hold_reset();
    poke(12'h000, 16'h2010); poke(12'h001, 16'hF200); poke(12'h002, 16'h4001);
    poke(12'h003, 16'hF800); poke(12'h004, 16'hF400); poke(12'h005, 16'h7001);
    poke(12'h010, 16'h1200);
    x = blank("R9 char io", 12'h006); x.ac = 16'h125A; x.oc = 8'h5A; x.of = 1'b0;
    go(x, 25, cyc);
    @(negedge clk); out_ack = 1'b1;
    @(negedge clk); out_ack = 1'b0;
    check("R9", "out_ack sets out_flag", 32'(out_flag), 32'h1);

    // R10: SKO taken, SKI not taken
    hold_reset();
    poke(12'h000, 16'hF100); poke(12'h001, 16'h7001); poke(12'h002, 16'hF200);
    poke(12'h003, 16'h7001);
    x = blank("R10 flag skips", 12'h004);
    go(x, 0, cyc);

    // R11: ION with no flags raised, no interrupt
    hold_reset();
    poke(12'h000, 16'hF400); poke(12'h001, 16'hF080); poke(12'h002, 16'h7001);
    x = blank("R11 ion", 12'h003); x.ien = 1'b1; x.of = 1'b0;
    x.nm = 1; x.ma0 = 12'h000; x.mv0 = 16'hF400;
    go(x, 0, cyc);

    // R11: IOF after ION
    hold_reset();
    poke(12'h000, 16'hF400); poke(12'h001, 16'hF080); poke(12'h002, 16'hF040);
    poke(12'h003, 16'h7001);
    x = blank("R11 iof", 12'h004); x.of = 1'b0;
    x.nm = 1; x.ma0 = 12'h000; x.mv0 = 16'hF400;
    go(x, 0, cyc);

    // R12: interrupt cycle saves the PC at word 0 and vectors to word 1
    hold_reset();
    poke(12'h000, 16'hF080); poke(12'h001, 16'h4020); poke(12'h020, 16'h7001);
    x = blank("R12 interrupt", 12'h021);
    x.nm = 1; x.ma0 = 12'h000; x.mv0 = 16'h0020;
    go(x, 0, cyc);

    finish_run();
  end
endmodule